// File: doc/BRIEF.md
# Complementary Dead-Time Pair Generator

This block turns the output of a PWM timer into a complementary pair of drive signals with a guard gap. Channels are grouped two by two: the even channel of each pair supplies the source waveform, and the odd channel becomes its complement when the pair's generator is switched on. Every time the source changes level, both outputs of the pair drop low. The newly active output is released only after a programmable dead interval. This keeps the two switches of a half-bridge from ever conducting at the same time.

The dead interval is an unsigned count of ticks. The tick is a one-cycle enable pulse from the prescaled clock selector of the pair's even channel, so the gap scales with that channel's prescaler and not with the system clock. When a pair's generator is off, both of its channels pass their own independent PWM inputs straight through. The PWM timers and prescalers themselves sit outside this block.

Top module: `cdt_gen`

## Requirements
- R1: While reset is asserted, both outputs of every enabled pair read 0.
- R2: When a pair's generator enable is 0, output channel 2p equals input channel 2p and output channel 2p+1 equals input channel 2p+1 in the same cycle. When the enable is 1, input channel 2p+1 has no effect on either output of the pair.
- R3: With the generator on and dead length D > 0, a rising source level sampled at clock edge E0 drives both outputs low after E0. Primary output 2p then goes high at the edge that samples the D-th asserted tick after E0.
- R4: With the generator on and D > 0, a falling source level sampled at edge E0 drives both outputs low after E0. Complementary output 2p+1 then goes high at the edge that samples the D-th asserted tick after E0.
- R5: The dead count advances only on clock edges where the pair's tick input is 1. Edges without a tick leave the remaining gap unchanged.
- R6: While the generator is on, outputs 2p and 2p+1 are never both 1.
- R7: A source high pulse that ends before its dead interval has expired produces no high level at all on primary output 2p.
- R8: With D = 0, after each clock edge primary output 2p equals the source level sampled at that edge and output 2p+1 is its inverse, with no gap.
- R9: When a pair's enable goes from 0 to 1, both outputs read 0 at once. The output matching the source level goes high at the edge that samples the D-th asserted tick, counted from the first edge that sees the enable high (for D = 0, at that first edge).
- R10: Each pair uses only its own enable, tick and dead length. Activity on one pair does not change the other pair's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pair_en | input | NUM_PAIRS | Generator enable, one bit per pair |
| pair_tick | input | NUM_PAIRS | Prescaled tick of each pair's even channel, one cycle wide |
| pair_dead | input | NUM_PAIRS*DEAD_W | Dead length in ticks; pair p uses bits [p*DEAD_W +: DEAD_W] |
| ch_pwm_in | input | 2*NUM_PAIRS | Raw PWM of each channel; bit 2p is pair p's source |
| ch_pwm_out | output | 2*NUM_PAIRS | Gated channel outputs; bit 2p primary, bit 2p+1 complement |

## Verification
Some properties are checked by assertions on every cycle. These cover the exclusion between the two outputs of a pair, the forced-low gap right after a source edge, the rule that a primary rise needs a high registered source (and a complement rise a low one), and the dead counter's step-by-one-per-tick behaviour. The assertions cannot fix exact cycle counts, so the bench scenarios have to show them. These are the release edge for a given dead length, counting stalled by missing ticks, the fully swallowed short pulse, the behaviour on enable, combinational bypass and independence between pairs.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
// cdt_pkg: shared types for the complementary dead-time generator.
// Assumes nothing beyond a synthesizable enum of two bits.
package cdt_pkg;

    // Channels making up one complementary pair.
    localparam int CH_PER_PAIR = 2;

    // Per-pair generator state: off (bypass), in the guard gap, or driving.
    typedef enum logic [1:0] {
        GEN_OFF = 2'd0,
        GEN_GAP = 2'd1,
        GEN_RUN = 2'd2
    } gen_state_e;

endpackage

// File: rtl/cdt_tick_timer.sv
`timescale 1ns/1ps
// cdt_tick_timer: down counter that measures the dead interval in ticks.
// A load reloads it with the dead length. Each tick-qualified cycle then
// removes one unit. The expire strobe marks the cycle whose tick takes the
// count from one to zero. Assumes load has priority over counting.
module cdt_tick_timer #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DEAD_W-1:0] load_val,
    input  logic              tick,
    output logic              busy,
    output logic              expire
);

    logic [DEAD_W-1:0] cnt_q;

    // Reload on request, otherwise step down once per tick until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy   = (cnt_q != '0);
    assign expire = tick && !load && (cnt_q == {{(DEAD_W-1){1'b0}}, 1'b1});

    // R5: a ticked cycle removes exactly one unit from a running count.
    assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: without a tick and without a reload the remaining gap is frozen.
    assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/cdt_pair_core.sv
`timescale 1ns/1ps
// cdt_pair_core: complementary generator for one channel pair.
// Registers the source and detects each level change. On a change it blanks
// both outputs and restarts the dead timer, then releases the output that
// matches the source once the timer has run out. When disabled it stays
// blank and keeps the timer preloaded, so enabling starts with a full gap.
// Assumes src is synchronous to clk.
module cdt_pair_core
    import cdt_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              tick,
    input  logic [DEAD_W-1:0] dead_len,
    input  logic              src,
    output logic              prim_q,
    output logic              comp_q
);

    logic       src_q;
    logic       edge_seen;
    logic       tmr_load;
    logic       tmr_busy;
    logic       tmr_expire;
    gen_state_e st_q;
    gen_state_e st_d;
    logic       prim_d;
    logic       comp_d;

    // Keep the previous source level to detect edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
        end else begin
            src_q <= src;
        end
    end

    assign edge_seen = src ^ src_q;
    assign tmr_load  = !gen_en || edge_seen;

    cdt_tick_timer #(
        .DEAD_W (DEAD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dead_len),
        .tick     (tick),
        .busy     (tmr_busy),
        .expire   (tmr_expire)
    );

    // Next state and output levels of the pair.
    always_comb begin
        st_d   = st_q;
        prim_d = prim_q;
        comp_d = comp_q;
        if (!gen_en) begin
            st_d   = GEN_OFF;
            prim_d = 1'b0;
            comp_d = 1'b0;
        end else if (edge_seen) begin
            if (dead_len == '0) begin
                st_d   = GEN_RUN;
                prim_d = src;
                comp_d = !src;
            end else begin
                st_d   = GEN_GAP;
                prim_d = 1'b0;
                comp_d = 1'b0;
            end
        end else begin
            case (st_q)
                GEN_OFF, GEN_GAP: begin
                    if (!tmr_busy || tmr_expire) begin
                        st_d   = GEN_RUN;
                        prim_d = src_q;
                        comp_d = !src_q;
                    end else begin
                        st_d   = GEN_GAP;
                        prim_d = 1'b0;
                        comp_d = 1'b0;
                    end
                end
                GEN_RUN: begin
                    prim_d = src_q;
                    comp_d = !src_q;
                end
                default: begin
                    st_d   = GEN_OFF;
                    prim_d = 1'b0;
                    comp_d = 1'b0;
                end
            endcase
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GEN_OFF;
            prim_q <= 1'b0;
            comp_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            prim_q <= prim_d;
            comp_q <= comp_d;
        end
    end

    // R6: the two generated outputs are mutually exclusive.
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(prim_q && comp_q));

    // R3: a source edge with a nonzero gap blanks both outputs next cycle.
    assert_gap_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && edge_seen && (dead_len != '0)) |=> (!prim_q && !comp_q));

    // R3: the primary output only rises while the registered source is high.
    assert_prim_rise_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prim_q) |-> src_q);

    // R4: the complementary output only rises while the source is low.
    assert_comp_rise_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comp_q) |-> !src_q);

    // R9: turning the generator on with a nonzero gap starts blanked.
    assert_enable_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en) |=> (!prim_q && !comp_q));

endmodule

// File: rtl/cdt_out_mux.sv
`timescale 1ns/1ps
// cdt_out_mux: chooses between the generated pair and the raw channel inputs.
// Bypass is combinational so that a disabled pair is transparent.
module cdt_out_mux (
    input  logic gen_en,
    input  logic raw_a,
    input  logic raw_b,
    input  logic gen_a,
    input  logic gen_b,
    output logic out_a,
    output logic out_b
);

    // Generated levels when enabled, own inputs otherwise.
    always_comb begin
        out_a = gen_en ? gen_a : raw_a;
        out_b = gen_en ? gen_b : raw_b;
    end

endmodule

// File: rtl/cdt_gen.sv
`timescale 1ns/1ps
// cdt_gen: complementary dead-time generator for NUM_PAIRS channel pairs.
// Pair p takes its source from channel 2p, its tick from the prescaler of
// channel 2p, and drives channels 2p (primary) and 2p+1 (complement).
// Assumes all inputs are synchronous to clk.
module cdt_gen
    import cdt_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int DEAD_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PAIRS-1:0]          pair_en,
    input  logic [NUM_PAIRS-1:0]          pair_tick,
    input  logic [NUM_PAIRS*DEAD_W-1:0]   pair_dead,
    input  logic [NUM_PAIRS*CH_PER_PAIR-1:0] ch_pwm_in,
    output logic [NUM_PAIRS*CH_PER_PAIR-1:0] ch_pwm_out
);

    localparam int NUM_CH = NUM_PAIRS * CH_PER_PAIR;

    logic [NUM_CH-1:0] gen_lvl;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        cdt_pair_core #(
            .DEAD_W (DEAD_W)
        ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_en   (pair_en[p]),
            .tick     (pair_tick[p]),
            .dead_len (pair_dead[p*DEAD_W +: DEAD_W]),
            .src      (ch_pwm_in[CH_PER_PAIR*p]),
            .prim_q   (gen_lvl[CH_PER_PAIR*p]),
            .comp_q   (gen_lvl[CH_PER_PAIR*p+1])
        );

        cdt_out_mux u_mux (
            .gen_en (pair_en[p]),
            .raw_a  (ch_pwm_in[CH_PER_PAIR*p]),
            .raw_b  (ch_pwm_in[CH_PER_PAIR*p+1]),
            .gen_a  (gen_lvl[CH_PER_PAIR*p]),
            .gen_b  (gen_lvl[CH_PER_PAIR*p+1]),
            .out_a  (ch_pwm_out[CH_PER_PAIR*p]),
            .out_b  (ch_pwm_out[CH_PER_PAIR*p+1])
        );
    end

endmodule

// File: tb/cdt_gen_tb.sv
`timescale 1ns/1ps
// cdt_gen_tb: directed scenarios, one task each, for the dead-time generator.
module cdt_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  en;
    logic [1:0]  tick;
    logic [15:0] dead;
    logic [3:0]  pin;
    logic [3:0]  pout;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cdt_gen #(.NUM_PAIRS(2), .DEAD_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_en    (en),
        .pair_tick  (tick),
        .pair_dead  (dead),
        .ch_pwm_in  (pin),
        .ch_pwm_out (pout)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    // Gap of d edges after the change, then the given pair-0 level {comp,prim}.
    task automatic expect_gap(string req, int d, logic [1:0] fin);
        for (int k = 0; k < d; k++) begin
            cyc();
            chk(req, {2'b00, pout[1:0]}, 4'b0000);
        end
        cyc();
        chk(req, {2'b00, pout[1:0]}, {2'b00, fin});
    endtask

    task automatic t_reset_r1();
        en = 2'b11; pin = 4'b0101; tick = 2'b11; dead = 16'h0303;
        repeat (3) cyc();
        chk("R1 reset outputs low", pout, 4'b0000);
        rst_n = 1'b1;
        en = 2'b00;
        cyc();
    endtask

    task automatic t_bypass_r2();
        logic [3:0] pats [5] = '{4'b0000, 4'b0101, 4'b1010, 4'b1111, 4'b0110};
        en = 2'b00;
        foreach (pats[i]) begin
            pin = pats[i];
            #1;
            chk("R2 bypass", pout, pats[i]);
        end
        en = 2'b01; dead[7:0] = 8'd0; pin = 4'b0000;
        repeat (3) cyc();
        chk("R2 enabled steady", {2'b00, pout[1:0]}, 4'b0010);
        pin[1] = 1'b1;
        cyc();
        chk("R2 odd input ignored", {2'b00, pout[1:0]}, 4'b0010);
        pin[1] = 1'b0;
    endtask

    task automatic t_rise_r3();
        en[0] = 1'b1; dead[7:0] = 8'd4; tick = 2'b11; pin[0] = 1'b0;
        repeat (8) cyc();
        chk("R3 steady low source", {2'b00, pout[1:0]}, 4'b0010);
        pin[0] = 1'b1;
        expect_gap("R3 rise gap", 4, 2'b01);
    endtask

    task automatic t_fall_r4();
        pin[0] = 1'b0;
        expect_gap("R4 fall gap", 4, 2'b10);
        dead[7:0] = 8'd1;
        pin[0] = 1'b1;
        expect_gap("R3 rise gap d1", 1, 2'b01);
    endtask

    task automatic t_tick_r5();
        dead[7:0] = 8'd2; tick[0] = 1'b1; pin[0] = 1'b1;
        repeat (6) cyc();
        tick[0] = 1'b0; pin[0] = 1'b0;
        cyc();
        chk("R5 load edge", {2'b00, pout[1:0]}, 4'b0000);
        repeat (4) begin
            cyc();
            chk("R5 no tick holds gap", {2'b00, pout[1:0]}, 4'b0000);
        end
        tick[0] = 1'b1;
        cyc();
        chk("R5 one tick", {2'b00, pout[1:0]}, 4'b0000);
        tick[0] = 1'b0;
        repeat (2) begin
            cyc();
            chk("R5 stalled", {2'b00, pout[1:0]}, 4'b0000);
        end
        tick[0] = 1'b1;
        cyc();
        chk("R5 second tick releases", {2'b00, pout[1:0]}, 4'b0010);
    endtask

    task automatic t_short_r7();
        dead[7:0] = 8'd5; tick[0] = 1'b1; pin[0] = 1'b0;
        repeat (8) cyc();
        pin[0] = 1'b1;
        repeat (3) begin
            cyc();
            chk("R7 short pulse primary low", {3'b000, pout[0]}, 4'b0000);
        end
        pin[0] = 1'b0;
        expect_gap("R7 after short pulse", 5, 2'b10);
    endtask

    task automatic t_zero_r8();
        dead[7:0] = 8'd0; tick[0] = 1'b1; pin[0] = 1'b0;
        repeat (3) cyc();
        for (int i = 0; i < 8; i++) begin
            pin[0] = (i % 3 == 2) ? pin[0] : ~pin[0];
            cyc();
            chk("R8 zero dead", {2'b00, pout[1:0]}, {2'b00, ~pin[0], pin[0]});
        end
    endtask

    task automatic t_overlap_r6();
        logic [7:0] lfsr = 8'hA5;
        int hits = 0;
        dead[7:0] = 8'd2; tick[0] = 1'b1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pin[0] = lfsr[0];
            tick[0] = lfsr[3] | lfsr[6];
            cyc();
            if (pout[1] && pout[0]) hits++;
        end
        chk("R6 overlap count", hits[3:0], 4'd0);
        tick[0] = 1'b1;
    endtask

    task automatic t_enable_r9();
        en[0] = 1'b0; dead[7:0] = 8'd3; tick[0] = 1'b1; pin[1:0] = 2'b11;
        repeat (3) cyc();
        en[0] = 1'b1;
        #1;
        chk("R9 blank at enable", {2'b00, pout[1:0]}, 4'b0000);
        repeat (2) begin
            cyc();
            chk("R9 gap after enable", {2'b00, pout[1:0]}, 4'b0000);
        end
        cyc();
        chk("R9 release after enable", {2'b00, pout[1:0]}, 4'b0001);
        en[0] = 1'b0;
        #1;
        chk("R2 bypass on disable", {2'b00, pout[1:0]}, 4'b0011);
        pin[1] = 1'b0;
    endtask

    task automatic t_pairs_r10();
        en = 2'b10; pin = 4'b0001; dead[15:8] = 8'd1; tick = 2'b11;
        repeat (4) cyc();
        chk("R10 pair1 steady", pout, 4'b1001);
        tick = 2'b01; pin[2] = 1'b1;
        repeat (4) begin
            cyc();
            chk("R10 pair1 waits own tick", pout, 4'b0001);
        end
        tick[1] = 1'b1;
        cyc();
        chk("R10 pair1 release", pout, 4'b0101);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        rst_n = 1'b0; en = '0; tick = '0; dead = '0; pin = '0;
        @(negedge clk);
        t_reset_r1();
        t_bypass_r2();
        t_rise_r3();
        t_fall_r4();
        t_tick_r5();
        t_short_r7();
        t_zero_r8();
        t_overlap_r6();
        t_enable_r9();
        t_pairs_r10();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule